// File: doc/BRIEF.md
# Two-Priority Scan Group Sequencer

This block decides which of up to eight scan groups owns a single serial converter, and when. Every group carries a mask that selects any subset of sixteen samplers, a high/low priority bit, a two-bit sample-time select, a continuous flag and a select code for each of the four multiplexed samplers. A trigger pulse makes a group pending. When the sequencer is free, it grants the most urgent pending group. The group's samplers stay in sample for an optional extra window and then all enter hold together. The held channels are then issued to the converter one after another, and a one-cycle completion pulse marks the end of the group.

Control is a four-state machine. IDLE waits for a pending group, and its grant transition moves to SAMPLE when the chosen preset is non-zero. With a zero preset it goes straight to CONVERT, or to DONE when the mask is empty. SAMPLE counts down the preset and then moves to CONVERT, or to DONE for an empty mask. CONVERT spends a fixed number of clocks on each channel and moves to DONE after the last one. DONE always returns to IDLE. On that DONE-to-IDLE transition a continuous group is made pending again. The converter core and all result processing sit outside the block. The block only marks each conversion slot with a start pulse, a channel index and a group index.

Top module: `scan_group_sequencer`

## Requirements
- R1: After reset no group is pending, `smp_hold` is all zero, and `conv_start` and `grp_done` are low until a trigger is seen.
- R2: When several groups are pending, every high-priority group (`grp_high` bit = 1) is granted before any low-priority group. Within one priority level the lowest group index is granted first. A new grant is made two cycles after the previous group's done pulse.
- R3: A trigger is sampled at clock edge k. A group with time select 0 is granted at edge k+1 with no extra window, so its first `conv_start` is visible right after edge k+1.
- R4: Time select values 1, 2 and 3 pick the presets in `time_preset` bits [5:0], [11:6] and [17:12]. A non-zero preset P delays the first conversion by exactly P cycles after the grant. A preset of 0 behaves like time select 0.
- R5: Throughout CONVERT, `smp_hold` equals the whole mask of the active group, so all selected samplers hold at once. `smp_hold` is zero during IDLE, SAMPLE and DONE.
- R6: The set samplers of a group are issued in ascending index order. Each one gets a one-cycle `conv_start` with its index on `conv_chan`, and consecutive starts are 16 cycles apart.
- R7: The granted group's bit of `grp_done` pulses for exactly one cycle, right after the edge where its last 16-cycle slot ends (grant edge + P + 16·N). No other bit is set in that cycle.
- R8: A trigger for a group that is already pending is ignored. That group completes only once.
- R9: A group whose `grp_cont` bit is set when it completes becomes pending again on the edge after its done pulse. When it is the only requester, a one-channel group repeats every 18 cycles. Clearing the bit stops the repetition after the current pass.
- R10: While a group converts, `mux_sel` carries that group's 8-bit mux select field (two bits per mux sampler, mux 0 in bits [1:0]).
- R11: A group with an empty mask issues no conversion. Its done pulse comes at grant edge + P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_trig | input | 8 | One trigger pulse bit per group |
| grp_mask | input | 128 | Sampler enable mask, 16 bits per group, group 0 lowest |
| grp_high | input | 8 | Priority bit per group, 1 = high |
| grp_time_sel | input | 16 | Two-bit sample-time select per group, 0 = none |
| grp_cont | input | 8 | Continuous-mode flag per group |
| grp_mux | input | 32 | Four 2-bit mux sampler selects per group |
| time_preset | input | 18 | Three 6-bit extra sample-time presets |
| smp_hold | output | 16 | Per-sampler hold, 1 = holding |
| mux_sel | output | 8 | Mux select of the active group |
| conv_start | output | 1 | Start pulse of a conversion slot |
| conv_chan | output | 4 | Sampler index of the current slot |
| conv_grp | output | 3 | Group index of the current slot |
| grp_done | output | 8 | One-cycle completion pulse per group |

## Verification
A corrupted pending vector shows up at the ports as a missing or doubled `grp_done` pulse, or as groups served out of priority order. Because the bench logs the exact cycle of every start and done, a wrong count or a skipped state moves every later timestamp of the batch, and the first affected conversion exposes it. The mask and channel registers are checked through `smp_hold` and `conv_chan` at each start pulse. The continuous rearm is visible as the 18-cycle spacing between done pulses.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAMPLE  = 2'd1,
        ST_CONVERT = 2'd2,
        ST_DONE    = 2'd3
    } ssq_state_e;

endpackage

// File: rtl/ssq_first_set.sv
module ssq_first_set #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);

    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = i[IW-1:0];
        end
        any = |vec;
    end

endmodule

// File: rtl/ssq_pend.sv
module ssq_pend #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] trig,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] rearm,
    output logic [N-1:0] pend
);

    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | (trig & ~pend) | rearm;
    end

    // R8: a pending request is only removed by its grant
    a_r8_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend) & ~$past(clr) & ~pend) == '0));

endmodule

// File: rtl/ssq_arbiter.sv
module ssq_arbiter #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  high,
    output logic [IW-1:0] gnt_idx,
    output logic          gnt_valid
);

    logic [N-1:0] req_hi;
    logic [N-1:0] req_use;

    always_comb begin
        req_hi  = req & high;
        req_use = (|req_hi) ? req_hi : (req & ~high);
    end

    ssq_first_set #(.W(N), .IW(IW)) u_pick (
        .vec (req_use),
        .idx (gnt_idx),
        .any (gnt_valid)
    );

endmodule

// File: rtl/scan_group_sequencer.sv
module scan_group_sequencer
    import ssq_pkg::*;
#(
    parameter int N_GROUPS   = 8,
    parameter int N_SAMPLERS = 16,
    parameter int N_MUX      = 4,
    parameter int MUX_SEL_W  = 2,
    parameter int PRESET_W   = 6,
    parameter int CONV_CLKS  = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [N_GROUPS-1:0]                   grp_trig,
    input  logic [N_GROUPS*N_SAMPLERS-1:0]        grp_mask,
    input  logic [N_GROUPS-1:0]                   grp_high,
    input  logic [2*N_GROUPS-1:0]                 grp_time_sel,
    input  logic [N_GROUPS-1:0]                   grp_cont,
    input  logic [N_GROUPS*N_MUX*MUX_SEL_W-1:0]   grp_mux,
    input  logic [3*PRESET_W-1:0]                 time_preset,
    output logic [N_SAMPLERS-1:0]                 smp_hold,
    output logic [N_MUX*MUX_SEL_W-1:0]            mux_sel,
    output logic                                  conv_start,
    output logic [$clog2(N_SAMPLERS)-1:0]         conv_chan,
    output logic [$clog2(N_GROUPS)-1:0]           conv_grp,
    output logic [N_GROUPS-1:0]                   grp_done
);

    localparam int GW     = $clog2(N_GROUPS);
    localparam int CW     = $clog2(N_SAMPLERS);
    localparam int MW     = N_MUX * MUX_SEL_W;
    localparam int CONV_W = $clog2(CONV_CLKS) + 1;
    localparam int CNTW   = (PRESET_W > CONV_W) ? PRESET_W : CONV_W;
    localparam logic [CNTW-1:0] SLOT_LAST = CNTW'(CONV_CLKS - 1);

    // per-group configuration views
    logic [N_SAMPLERS-1:0] mask_arr [N_GROUPS];
    logic [MW-1:0]         mux_arr  [N_GROUPS];
    logic [1:0]            sel_arr  [N_GROUPS];

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_unpack
        assign mask_arr[g] = grp_mask[g*N_SAMPLERS +: N_SAMPLERS];
        assign mux_arr[g]  = grp_mux[g*MW +: MW];
        assign sel_arr[g]  = grp_time_sel[2*g +: 2];
    end

    ssq_state_e            state_q, state_d;
    logic [GW-1:0]         act_grp_q;
    logic [N_SAMPLERS-1:0] rem_q;
    logic [N_SAMPLERS-1:0] full_q;
    logic [MW-1:0]         act_mux_q;
    logic                  act_hi_q;
    logic [CNTW-1:0]       cnt_q;

    logic [N_GROUPS-1:0]   pend;
    logic [N_GROUPS-1:0]   pend_clr;
    logic [N_GROUPS-1:0]   pend_rearm;
    logic [GW-1:0]         gnt_idx;
    logic                  gnt_valid;
    logic                  grant;
    logic [CW-1:0]         chan_idx;
    logic                  rem_any;
    logic [N_SAMPLERS-1:0] rem_next;
    logic [N_SAMPLERS-1:0] g_mask;
    logic [1:0]            g_sel;
    logic [PRESET_W-1:0]   g_preset;

    ssq_pend #(.N(N_GROUPS)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (grp_trig),
        .clr   (pend_clr),
        .rearm (pend_rearm),
        .pend  (pend)
    );

    ssq_arbiter #(.N(N_GROUPS), .IW(GW)) u_arb (
        .req       (pend),
        .high      (grp_high),
        .gnt_idx   (gnt_idx),
        .gnt_valid (gnt_valid)
    );

    ssq_first_set #(.W(N_SAMPLERS), .IW(CW)) u_chan (
        .vec (rem_q),
        .idx (chan_idx),
        .any (rem_any)
    );

    // grant-side decode
    always_comb begin
        g_mask = mask_arr[gnt_idx];
        g_sel  = sel_arr[gnt_idx];
        unique case (g_sel)
            2'd0: g_preset = '0;
            2'd1: g_preset = time_preset[0 +: PRESET_W];
            2'd2: g_preset = time_preset[PRESET_W +: PRESET_W];
            2'd3: g_preset = time_preset[2*PRESET_W +: PRESET_W];
        endcase
        grant      = (state_q == ST_IDLE) && gnt_valid;
        pend_clr   = grant ? (N_GROUPS'(1) << gnt_idx) : '0;
        pend_rearm = ((state_q == ST_DONE) && grp_cont[act_grp_q])
                     ? (N_GROUPS'(1) << act_grp_q) : '0;
        rem_next   = rem_q & ~(N_SAMPLERS'(1) << chan_idx);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (gnt_valid) begin
                    if (g_preset != '0)      state_d = ST_SAMPLE;
                    else if (g_mask == '0)   state_d = ST_DONE;
                    else                     state_d = ST_CONVERT;
                end
            end
            ST_SAMPLE: begin
                if (cnt_q == CNTW'(1)) state_d = rem_any ? ST_CONVERT : ST_DONE;
            end
            ST_CONVERT: begin
                if (cnt_q == '0 && rem_next == '0) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // group context and timing counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_grp_q <= '0;
            rem_q     <= '0;
            full_q    <= '0;
            act_mux_q <= '0;
            act_hi_q  <= 1'b0;
            cnt_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (gnt_valid) begin
                        act_grp_q <= gnt_idx;
                        rem_q     <= g_mask;
                        full_q    <= g_mask;
                        act_mux_q <= mux_arr[gnt_idx];
                        act_hi_q  <= grp_high[gnt_idx];
                        cnt_q     <= (g_preset == '0) ? SLOT_LAST : CNTW'(g_preset);
                    end
                end
                ST_SAMPLE: begin
                    cnt_q <= (cnt_q == CNTW'(1)) ? SLOT_LAST : cnt_q - CNTW'(1);
                end
                ST_CONVERT: begin
                    if (cnt_q == '0) begin
                        rem_q <= rem_next;
                        cnt_q <= SLOT_LAST;
                    end else begin
                        cnt_q <= cnt_q - CNTW'(1);
                    end
                end
                ST_DONE: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        smp_hold   = (state_q == ST_CONVERT) ? full_q : '0;
        conv_start = (state_q == ST_CONVERT) && (cnt_q == SLOT_LAST) && rem_any;
        conv_chan  = chan_idx;
        conv_grp   = act_grp_q;
        mux_sel    = act_mux_q;
        grp_done   = (state_q == ST_DONE) ? (N_GROUPS'(1) << act_grp_q) : '0;
    end

    // R7: at most one completion pulse, and only straight after conversion or timing
    a_r7_done_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grp_done));
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        (|grp_done) |=> (grp_done == '0));

    // R6: an issued channel is held, and starts never come back to back
    a_r6_start_held: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> smp_hold[conv_chan]);
    a_r6_start_gap: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R5: the held set does not change while a group converts
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONVERT && $past(state_q) == ST_CONVERT) |-> $stable(smp_hold));

    // R2: a pending high-priority group wins the next grant
    a_r2_high_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && |(pend & grp_high)) |=> act_hi_q);

endmodule

// File: tb/tb_scan_group_sequencer.sv
module tb_scan_group_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int NG = 8;
    localparam int NS = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NG-1:0]    grp_trig = '0;
    logic [NG*NS-1:0] grp_mask;
    logic [NG-1:0]    grp_high;
    logic [2*NG-1:0]  grp_time_sel;
    logic [NG-1:0]    grp_cont;
    logic [NG*8-1:0]  grp_mux;
    logic [17:0]      time_preset;
    logic [NS-1:0]    smp_hold;
    logic [7:0]       mux_sel;
    logic             conv_start;
    logic [3:0]       conv_chan;
    logic [2:0]       conv_grp;
    logic [NG-1:0]    grp_done;

    logic [15:0] m   [NG];
    logic        hi  [NG];
    logic [1:0]  sel [NG];
    logic        cnt_mode [NG];
    logic [7:0]  mx  [NG];
    logic [5:0]  pre [3];

    always_comb begin
        for (int g = 0; g < NG; g++) begin
            grp_mask[g*NS +: NS]   = m[g];
            grp_high[g]            = hi[g];
            grp_time_sel[2*g +: 2] = sel[g];
            grp_cont[g]            = cnt_mode[g];
            grp_mux[8*g +: 8]      = mx[g];
        end
        for (int p = 0; p < 3; p++) time_preset[6*p +: 6] = pre[p];
    end

    scan_group_sequencer dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .grp_trig     (grp_trig),
        .grp_mask     (grp_mask),
        .grp_high     (grp_high),
        .grp_time_sel (grp_time_sel),
        .grp_cont     (grp_cont),
        .grp_mux      (grp_mux),
        .time_preset  (time_preset),
        .smp_hold     (smp_hold),
        .mux_sel      (mux_sel),
        .conv_start   (conv_start),
        .conv_chan    (conv_chan),
        .conv_grp     (conv_grp),
        .grp_done     (grp_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;

    // event logs, filled away from the active edge
    int          ev_n = 0;
    int          ev_cyc  [256];
    int          ev_grp  [256];
    int          ev_chan [256];
    logic [15:0] ev_hold [256];
    logic [7:0]  ev_mux  [256];
    int          dn_n = 0;
    int          dn_cyc  [64];
    int          dn_grp  [64];
    logic [15:0] dn_hold [64];

    always @(negedge clk) begin
        if (rst_n) begin
            if (conv_start && ev_n < 256) begin
                ev_cyc[ev_n]  = cyc;
                ev_grp[ev_n]  = int'(conv_grp);
                ev_chan[ev_n] = int'(conv_chan);
                ev_hold[ev_n] = smp_hold;
                ev_mux[ev_n]  = mux_sel;
                ev_n++;
            end
            if (grp_done != '0 && dn_n < 64) begin
                dn_cyc[dn_n] = cyc;
                dn_grp[dn_n] = -1;
                for (int g = NG - 1; g >= 0; g--) if (grp_done[g]) dn_grp[dn_n] = g;
                if ($countones(grp_done) != 1) dn_grp[dn_n] = 99;
                dn_hold[dn_n] = smp_hold;
                dn_n++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    task automatic fire(input logic [7:0] v, output int k);
        @(negedge clk);
        grp_trig = v;
        k = cyc + 1;
        @(negedge clk);
        grp_trig = '0;
    endtask

    task automatic wait_dones(input int n, input int limit);
        int w = 0;
        while (dn_n < n && w < limit) begin
            @(negedge clk);
            w++;
        end
        if (dn_n < n) check(1'b0, "watchdog-done", dn_n, n);
    endtask

    function automatic int preset_of(input int g);
        if (sel[g] == 2'd0) return 0;
        return int'(pre[int'(sel[g]) - 1]);
    endfunction

    // Expected schedule from the requirements: grant order R2, delay R3/R4,
    // ascending 16-cycle slots R6, done timing R7, empty mask R11
    task automatic run_batch(input logic [7:0] v, output int k);
        int e = 0;
        int d = 0;
        int t;
        int want = $countones(v);
        ev_n = 0;
        dn_n = 0;
        fire(v, k);
        wait_dones(want, 6000);
        repeat (4) @(negedge clk);
        t = k + 1;
        for (int pass = 1; pass >= 0; pass--) begin
            for (int g = 0; g < NG; g++) begin
                if (v[g] && int'(hi[g]) == pass) begin
                    int p = preset_of(g);
                    int j = 0;
                    for (int b = 0; b < NS; b++) begin
                        if (m[g][b]) begin
                            check(ev_grp[e] == g, "R2 group order", ev_grp[e], g);
                            check(ev_chan[e] == b, "R6 channel order", ev_chan[e], b);
                            check(ev_cyc[e] == t + p + 16*j, "R3/R4/R6 start cycle",
                                  ev_cyc[e], t + p + 16*j);
                            check(ev_hold[e] == m[g], "R5 hold set",
                                  int'(ev_hold[e]), int'(m[g]));
                            check(ev_mux[e] == mx[g], "R10 mux select",
                                  int'(ev_mux[e]), int'(mx[g]));
                            e++;
                            j++;
                        end
                    end
                    check(dn_grp[d] == g, "R7 done group", dn_grp[d], g);
                    check(dn_cyc[d] == t + p + 16*j, "R7 done cycle", dn_cyc[d], t + p + 16*j);
                    check(dn_hold[d] == '0, "R5 hold released", int'(dn_hold[d]), 0);
                    t = t + p + 16*j + 2;
                    d++;
                end
            end
        end
        check(ev_n == e, "R6 start count", ev_n, e);
        check(dn_n == d, "R7 done count", dn_n, d);
    endtask

    initial begin
        int k;
        int cnt3;
        int stop_n;
        void'($urandom(32'h5EED_0042));
        for (int g = 0; g < NG; g++) begin
            m[g] = '0; hi[g] = 1'b0; sel[g] = 2'd0; cnt_mode[g] = 1'b0; mx[g] = '0;
        end
        pre[0] = 6'd5; pre[1] = 6'd9; pre[2] = 6'd2;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: quiet after reset
        repeat (5) begin
            @(negedge clk);
            check(smp_hold == '0, "R1 hold after reset", int'(smp_hold), 0);
            check(conv_start == 1'b0, "R1 start after reset", int'(conv_start), 0);
            check(grp_done == '0, "R1 done after reset", int'(grp_done), 0);
        end

        // R3 R6 R7 R10: single group, no extra sample time
        m[0] = 16'h0025; mx[0] = 8'hE4;
        run_batch(8'h01, k);

        // R4: each preset in turn
        m[1] = 16'h0003; sel[1] = 2'd1; mx[1] = 8'h1B;
        run_batch(8'h02, k);
        m[2] = 16'h8001; sel[2] = 2'd2;
        run_batch(8'h04, k);
        m[3] = 16'h0400; sel[3] = 2'd3;
        run_batch(8'h08, k);
        pre[1] = 6'd0;
        run_batch(8'h04, k);   // R4: a zero preset acts like no extra time
        pre[1] = 6'd9;

        // R2: mixed priorities triggered together
        for (int g = 0; g < NG; g++) sel[g] = 2'd0;
        hi[2] = 1'b1; hi[5] = 1'b1;
        m[5] = 16'h0110; mx[5] = 8'h55;
        run_batch(8'h27, k);

        // R11: empty mask, with and without extra time
        m[6] = '0;
        run_batch(8'h40, k);
        check(ev_n == 0 && dn_n == 1 && dn_cyc[0] == k + 1, "R11 empty no extra",
              dn_cyc[0], k + 1);
        sel[6] = 2'd2;
        run_batch(8'h40, k);
        check(ev_n == 0 && dn_n == 1 && dn_cyc[0] == k + 10, "R11 empty with preset",
              dn_cyc[0], k + 10);
        sel[6] = 2'd0;

        // R8: repeated trigger of a pending group
        hi = '{default: 1'b0};
        hi[2] = 1'b1; m[2] = 16'hFFFF; m[3] = 16'h0001; sel[2] = 2'd0; sel[3] = 2'd0;
        ev_n = 0; dn_n = 0;
        fire(8'h04, k);
        repeat (10) @(negedge clk);
        fire(8'h08, k);
        repeat (20) @(negedge clk);
        fire(8'h08, k);
        wait_dones(2, 2000);
        repeat (200) @(negedge clk);
        cnt3 = 0;
        for (int i = 0; i < dn_n; i++) if (dn_grp[i] == 3) cnt3++;
        check(cnt3 == 1, "R8 pending trigger ignored", cnt3, 1);
        check(dn_n == 2, "R8 total completions", dn_n, 2);

        // R9: continuous re-arm and stop
        m[4] = 16'h0100; cnt_mode[4] = 1'b1; sel[4] = 2'd0;
        ev_n = 0; dn_n = 0;
        fire(8'h10, k);
        wait_dones(3, 500);
        check(dn_cyc[0] == k + 17, "R9 first pass", dn_cyc[0], k + 17);
        check(dn_cyc[1] - dn_cyc[0] == 18, "R9 repeat period", dn_cyc[1] - dn_cyc[0], 18);
        check(dn_cyc[2] - dn_cyc[1] == 18, "R9 repeat period", dn_cyc[2] - dn_cyc[1], 18);
        cnt_mode[4] = 1'b0;
        repeat (60) @(negedge clk);
        stop_n = dn_n;
        repeat (60) @(negedge clk);
        check(dn_n == stop_n, "R9 stops when cleared", dn_n, stop_n);

        // constrained random batches (R2 R4 R5 R6 R7 R10 R11)
        for (int b = 0; b < 25; b++) begin
            logic [7:0] v;
            for (int g = 0; g < NG; g++) begin
                m[g]  = 16'($urandom);
                if ($urandom % 8 == 0) m[g] = '0;
                hi[g]  = 1'($urandom % 2);
                sel[g] = 2'($urandom % 4);
                mx[g]  = 8'($urandom);
                cnt_mode[g] = 1'b0;
            end
            for (int p = 0; p < 3; p++) pre[p] = 6'(1 + $urandom % 15);
            v = 8'($urandom);
            if (v == '0) v = 8'h81;
            run_batch(v, k);
        end

        finish_run();
    end

endmodule